// File: doc/BRIEF.md
# Multi-Cycle Processor Phase Controller

This block is the hardwired sequencer of a single-issue processor that runs one instruction at a time. It walks each instruction through a fetch phase, a decode phase and then only the later phases that the instruction's class needs: execute, memory access and register write-back. In each phase it drives the strobes that steer an external datapath: the ALU operation select, the ALU second-operand source, register-file write, memory read and write, the write-back source, the PC source and PC write enable, the instruction-register load, and a flag-update enable.

Its inputs are the 4-bit opcode field of the instruction register and the registered zero flag. The zero flag is used only by the branch-if-not-zero instruction. A halt instruction, or any opcode without a defined meaning, parks the controller in a terminal state. The controller leaves that state only on reset, and it raises `halted` while it is there.

Top module: `mcCtrl`

## Requirements
- R1: While `rstN` is low, every strobe output and `halted` are 0. The first cycle after reset is released is a fetch cycle.
- R2: A fetch cycle asserts `memRead`, `irWrite` and `pcWrite` with `pcSrc`=0, ignoring `opcode` and `zeroFlag`. It is always followed by a decode cycle, in which every strobe is 0.
- R3: Register-register ALU opcodes take 4 cycles: fetch, decode, execute and write-back. The opcodes are ADD=0010, SUB=0011, AND=0100, OR=0101 and MOV=0111. In execute, `aluSrc`=0 and `aluOp` is ADD=0, SUB=1, AND=2, OR=3 or PASS=4 (for MOV). Write-back asserts `regWrite` with `memToReg`=0.
- R4: MOVI=0110 takes 4 cycles. Its execute cycle drives `aluOp`=PASS(4) with `aluSrc`=1, and its write-back cycle is the same as in R3.
- R5: LOAD=0000 takes 5 cycles. Execute drives `aluOp`=ADD with `aluSrc`=1. Memory access asserts only `memRead`. Write-back asserts `regWrite` with `memToReg`=1.
- R6: STORE=0001 takes 4 cycles. Its execute cycle is the same as LOAD's. Memory access asserts only `memWrite`, and the next cycle is a fetch with no write-back.
- R7: BNZ=1000 takes 3 cycles. Execute drives `aluOp`=ADD with `aluSrc`=1. It asserts `pcSrc` and `pcWrite` exactly when `zeroFlag`=0, and asserts neither when `zeroFlag`=1.
- R8: HALT=1111 and the undefined opcodes 1001 to 1110 take 2 cycles (fetch and decode). After that, `halted`=1 and every other strobe is 0 on every cycle, whatever `opcode` and `zeroFlag` do, until reset.
- R9: `memRead` and `memWrite` are never 1 in the same cycle.
- R10: `flagWrite` is 1 only in the execute cycle of ADD, SUB, AND, OR and MOV, and never for MOVI, LOAD, STORE or BNZ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Opcode field of the instruction register |
| zeroFlag | input | 1 | Registered zero flag from the datapath |
| aluOp | output | 3 | ALU operation select |
| aluSrc | output | 1 | ALU second operand: 0 register, 1 immediate |
| regWrite | output | 1 | Register-file write enable |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| memToReg | output | 1 | Write-back source: 0 ALU result, 1 memory data |
| pcSrc | output | 1 | PC source: 0 incremented PC, 1 branch target |
| pcWrite | output | 1 | PC load enable |
| irWrite | output | 1 | Instruction-register load enable |
| flagWrite | output | 1 | Status-flag update enable |
| halted | output | 1 | High while parked in the terminal state |

## Verification
The assertions assume that `opcode` stays constant from the decode cycle to the last phase of an instruction, because it comes from an instruction register that only loads during fetch. They also assume that reset is held low across at least one rising clock edge. The stimulus changes `opcode` only during fetch cycles, where it puts a deliberately different value on it, and changes `zeroFlag` to its opposite value outside execute. Reset is always applied for two full cycles, including once in the middle of a load.

// File: rtl/mcCtrlPkg.sv
package mcCtrlPkg;

  localparam int OPC_W   = 4;
  localparam int ALUOP_W = 3;
  localparam int PHASE_W = 3;
  localparam int CLASS_W = 3;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_SUB   = 4'b0011;
  localparam logic [OPC_W-1:0] OPC_AND   = 4'b0100;
  localparam logic [OPC_W-1:0] OPC_OR    = 4'b0101;
  localparam logic [OPC_W-1:0] OPC_MOVI  = 4'b0110;
  localparam logic [OPC_W-1:0] OPC_MOV   = 4'b0111;
  localparam logic [OPC_W-1:0] OPC_BNZ   = 4'b1000;

  typedef enum logic [ALUOP_W-1:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_OR   = 3'd3,
    ALU_PASS = 3'd4
  } aluOp_e;

  typedef enum logic [PHASE_W-1:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_EXEC   = 3'd2,
    PH_MEM    = 3'd3,
    PH_WB     = 3'd4,
    PH_HALT   = 3'd5
  } phase_e;

  typedef enum logic [CLASS_W-1:0] {
    CL_ALU_RR  = 3'd0,
    CL_ALU_IMM = 3'd1,
    CL_LOAD    = 3'd2,
    CL_STORE   = 3'd3,
    CL_BRANCH  = 3'd4,
    CL_HALT    = 3'd5
  } opClass_e;

  typedef struct packed {
    aluOp_e aluOp;
    logic   aluSrc;
    logic   regWrite;
    logic   memRead;
    logic   memWrite;
    logic   memToReg;
    logic   pcSrc;
    logic   pcWrite;
    logic   irWrite;
    logic   flagWrite;
  } strobes_t;

  // Any code not listed falls into the terminal class.
  function automatic opClass_e classify(input logic [OPC_W-1:0] opc);
    case (opc)
      OPC_ADD, OPC_SUB, OPC_AND, OPC_OR, OPC_MOV: return CL_ALU_RR;
      OPC_MOVI:  return CL_ALU_IMM;
      OPC_LOAD:  return CL_LOAD;
      OPC_STORE: return CL_STORE;
      OPC_BNZ:   return CL_BRANCH;
      default:   return CL_HALT;
    endcase
  endfunction

  function automatic aluOp_e aluFor(input logic [OPC_W-1:0] opc);
    case (opc)
      OPC_SUB: return ALU_SUB;
      OPC_AND: return ALU_AND;
      OPC_OR:  return ALU_OR;
      OPC_MOV: return ALU_PASS;
      default: return ALU_ADD;
    endcase
  endfunction

endpackage

// File: rtl/mcCtrlSeq.sv
module mcCtrlSeq
  import mcCtrlPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OPC_W-1:0] opcode,
  output phase_e           phase
);

  phase_e   phaseNxt;
  opClass_e cls;

  assign cls = classify(opcode);

  always_comb begin
    phaseNxt = phase;
    case (phase)
      PH_FETCH:  phaseNxt = PH_DECODE;
      PH_DECODE: phaseNxt = (cls == CL_HALT) ? PH_HALT : PH_EXEC;
      PH_EXEC: begin
        case (cls)
          CL_LOAD, CL_STORE: phaseNxt = PH_MEM;
          CL_BRANCH:         phaseNxt = PH_FETCH;
          default:           phaseNxt = PH_WB;
        endcase
      end
      PH_MEM:    phaseNxt = (cls == CL_LOAD) ? PH_WB : PH_FETCH;
      PH_WB:     phaseNxt = PH_FETCH;
      PH_HALT:   phaseNxt = PH_HALT;
      default:   phaseNxt = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_FETCH;
    else       phase <= phaseNxt;
  end

endmodule

// File: rtl/mcCtrlStrobe.sv
module mcCtrlStrobe
  import mcCtrlPkg::*;
(
  input  phase_e           phase,
  input  logic [OPC_W-1:0] opcode,
  input  logic             zeroFlag,
  output strobes_t         strobes
);

  opClass_e cls;
  assign cls = classify(opcode);

  always_comb begin
    strobes = '0;
    case (phase)
      PH_FETCH: begin
        strobes.memRead = 1'b1;
        strobes.irWrite = 1'b1;
        strobes.pcWrite = 1'b1;
      end
      PH_EXEC: begin
        case (cls)
          CL_ALU_RR: begin
            strobes.aluOp     = aluFor(opcode);
            strobes.flagWrite = 1'b1;
          end
          CL_ALU_IMM: begin
            strobes.aluOp  = ALU_PASS;
            strobes.aluSrc = 1'b1;
          end
          CL_LOAD, CL_STORE: begin
            strobes.aluOp  = ALU_ADD;
            strobes.aluSrc = 1'b1;
          end
          CL_BRANCH: begin
            strobes.aluOp   = ALU_ADD;
            strobes.aluSrc  = 1'b1;
            strobes.pcSrc   = !zeroFlag;
            strobes.pcWrite = !zeroFlag;
          end
          default: ;
        endcase
      end
      PH_MEM: begin
        strobes.memRead  = (cls == CL_LOAD);
        strobes.memWrite = (cls == CL_STORE);
      end
      PH_WB: begin
        strobes.regWrite = 1'b1;
        strobes.memToReg = (cls == CL_LOAD);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mcCtrl.sv
module mcCtrl
  import mcCtrlPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [OPC_W-1:0]   opcode,
  input  logic               zeroFlag,
  output logic [ALUOP_W-1:0] aluOp,
  output logic               aluSrc,
  output logic               regWrite,
  output logic               memRead,
  output logic               memWrite,
  output logic               memToReg,
  output logic               pcSrc,
  output logic               pcWrite,
  output logic               irWrite,
  output logic               flagWrite,
  output logic               halted
);

  phase_e   phase;
  strobes_t rawStrobes;
  strobes_t outStrobes;

  mcCtrlSeq seq_i (
    .clk    (clk),
    .rstN   (rstN),
    .opcode (opcode),
    .phase  (phase)
  );

  mcCtrlStrobe strobe_i (
    .phase    (phase),
    .opcode   (opcode),
    .zeroFlag (zeroFlag),
    .strobes  (rawStrobes)
  );

  assign outStrobes = rstN ? rawStrobes : '0;

  assign aluOp     = outStrobes.aluOp;
  assign aluSrc    = outStrobes.aluSrc;
  assign regWrite  = outStrobes.regWrite;
  assign memRead   = outStrobes.memRead;
  assign memWrite  = outStrobes.memWrite;
  assign memToReg  = outStrobes.memToReg;
  assign pcSrc     = outStrobes.pcSrc;
  assign pcWrite   = outStrobes.pcWrite;
  assign irWrite   = outStrobes.irWrite;
  assign flagWrite = outStrobes.flagWrite;
  assign halted    = rstN && (phase == PH_HALT);

endmodule

// File: rtl/mcCtrlChk.sv
module mcCtrlChk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] aluOp,
  input logic       aluSrc,
  input logic       regWrite,
  input logic       memRead,
  input logic       memWrite,
  input logic       memToReg,
  input logic       pcSrc,
  input logic       pcWrite,
  input logic       irWrite,
  input logic       flagWrite,
  input logic       halted
);

  // R1: quiet outputs while reset is held
  always_comb begin
    if (rstN === 1'b0) begin
      p_reset_quiet_r1: assert (!(regWrite || memRead || memWrite || pcWrite ||
                                  irWrite || flagWrite || halted || pcSrc));
    end
  end

  p_decode_after_fetch_r2: assert property (@(posedge clk) disable iff (!rstN)
    irWrite |=> !(irWrite || memRead || memWrite || pcWrite || regWrite || flagWrite));

  p_wb_then_fetch_r3: assert property (@(posedge clk) disable iff (!rstN)
    regWrite |=> irWrite);

  p_load_mem_then_wb_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memRead && !irWrite) |=> (regWrite && memToReg));

  p_store_then_fetch_r6: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |=> irWrite);

  p_branch_target_r7: assert property (@(posedge clk) disable iff (!rstN)
    pcSrc |-> (pcWrite && !irWrite && aluSrc));

  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !(regWrite || memRead || memWrite || pcWrite || irWrite || flagWrite));

  p_mem_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(memRead && memWrite));

  p_flag_alu_only_r10: assert property (@(posedge clk) disable iff (!rstN)
    flagWrite |-> (!aluSrc && !pcWrite && !memRead && !memWrite && aluOp <= 3'd4));

  p_flag_then_wb_r10: assert property (@(posedge clk) disable iff (!rstN)
    flagWrite |=> (regWrite && !memToReg));

endmodule

bind mcCtrl mcCtrlChk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .aluOp     (aluOp),
  .aluSrc    (aluSrc),
  .regWrite  (regWrite),
  .memRead   (memRead),
  .memWrite  (memWrite),
  .memToReg  (memToReg),
  .pcSrc     (pcSrc),
  .pcWrite   (pcWrite),
  .irWrite   (irWrite),
  .flagWrite (flagWrite),
  .halted    (halted)
);

// File: tb/mcCtrl_tb_top.sv
module mcCtrl_tb_top;

  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  localparam logic [3:0] OP_LOAD = 4'b0000, OP_STORE = 4'b0001, OP_ADD = 4'b0010,
                         OP_SUB  = 4'b0011, OP_AND   = 4'b0100, OP_OR  = 4'b0101,
                         OP_MOVI = 4'b0110, OP_MOV   = 4'b0111, OP_BNZ = 4'b1000,
                         OP_HALT = 4'b1111;
  localparam logic [2:0] A_ADD = 3'd0, A_SUB = 3'd1, A_AND = 3'd2, A_OR = 3'd3, A_PASS = 3'd4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] opcode = 4'b0;
  logic       zeroFlag = 1'b0;
  logic [2:0] aluOp;
  logic aluSrc, regWrite, memRead, memWrite, memToReg, pcSrc, pcWrite, irWrite, flagWrite, halted;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcCtrl dut_i (
    .clk(clk), .rstN(rstN), .opcode(opcode), .zeroFlag(zeroFlag),
    .aluOp(aluOp), .aluSrc(aluSrc), .regWrite(regWrite), .memRead(memRead),
    .memWrite(memWrite), .memToReg(memToReg), .pcSrc(pcSrc), .pcWrite(pcWrite),
    .irWrite(irWrite), .flagWrite(flagWrite), .halted(halted)
  );

  wire [12:0] actual = {halted, flagWrite, irWrite, pcWrite, pcSrc, memToReg,
                        memWrite, memRead, regWrite, aluSrc, aluOp};

  function automatic logic [12:0] mk(input logic [2:0] a, input logic src, rw, mr, mw,
                                     m2r, ps, pw, ir, fw, h);
    return {h, fw, ir, pw, ps, m2r, mw, mr, rw, src, a};
  endfunction

  localparam logic [12:0] W_ZERO   = 13'b0;
  localparam logic [12:0] W_HALTED = 13'b1_0000_0000_0000;

  task automatic check(input logic [12:0] exp, input string tag);
    checks++;
    if (actual !== exp) begin
      errors++;
      $display("FAIL %s: strobes actual=%b expected=%b", tag, actual, exp);
    end
    checks++;
    if (memRead && memWrite) begin
      errors++;
      $display("FAIL R9: memRead=%b memWrite=%b expected not both high", memRead, memWrite);
    end
  endtask

  // Reference model: expected strobe words for one instruction, one per cycle.
  task automatic runInstr(input logic [3:0] op, input logic z, input int maxCycles);
    logic [12:0] exp[$];
    string       tg[$];
    exp.push_back(mk(A_ADD, 0, 0, 1, 0, 0, 0, 1, 1, 0, 0)); tg.push_back("R2 fetch");
    exp.push_back(W_ZERO);                                  tg.push_back("R2 decode");
    case (op)
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_MOV: begin
        logic [2:0] a;
        a = (op == OP_ADD) ? A_ADD : (op == OP_SUB) ? A_SUB : (op == OP_AND) ? A_AND :
            (op == OP_OR) ? A_OR : A_PASS;
        exp.push_back(mk(a, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0)); tg.push_back("R3/R10 execute");
        exp.push_back(mk(A_ADD, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0)); tg.push_back("R3 writeback");
      end
      OP_MOVI: begin
        exp.push_back(mk(A_PASS, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0)); tg.push_back("R4 execute");
        exp.push_back(mk(A_ADD, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0)); tg.push_back("R4 writeback");
      end
      OP_LOAD: begin
        exp.push_back(mk(A_ADD, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0)); tg.push_back("R5 execute");
        exp.push_back(mk(A_ADD, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0)); tg.push_back("R5 memory");
        exp.push_back(mk(A_ADD, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0)); tg.push_back("R5 writeback");
      end
      OP_STORE: begin
        exp.push_back(mk(A_ADD, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0)); tg.push_back("R6 execute");
        exp.push_back(mk(A_ADD, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0)); tg.push_back("R6 memory");
      end
      OP_BNZ: begin
        exp.push_back(mk(A_ADD, 1, 0, 0, 0, 0, !z, !z, 0, 0, 0)); tg.push_back("R7 execute");
      end
      default: ;
    endcase
    for (int i = 0; i < exp.size() && i < maxCycles; i++) begin
      @(negedge clk);
      rstN     = 1'b1;
      opcode   = (i == 0) ? ~op : op;
      zeroFlag = (i == 2) ? z : ~z;
      #1 check(exp[i], tg[i]);
    end
  endtask

  task automatic haltedCycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      opcode   = 4'(i * 5);
      zeroFlag = i[0];
      #1 check(W_HALTED, "R8 parked");
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN   = 1'b0;
    opcode = OP_ADD;
    #1 check(W_ZERO, "R1 reset");
    @(negedge clk);
    #1 check(W_ZERO, "R1 reset");
  endtask

  initial begin
    #1 check(W_ZERO, "R1 reset");
    doReset();
    // R3 / R10: every register-register operation
    runInstr(OP_ADD, 0, 99);
    runInstr(OP_SUB, 1, 99);
    runInstr(OP_AND, 0, 99);
    runInstr(OP_OR,  1, 99);
    runInstr(OP_MOV, 0, 99);
    runInstr(OP_MOVI, 0, 99);   // R4
    runInstr(OP_LOAD, 1, 99);   // R5
    runInstr(OP_STORE, 0, 99);  // R6
    runInstr(OP_LOAD, 0, 99);   // R5 back to back
    runInstr(OP_BNZ, 0, 99);    // R7 taken
    runInstr(OP_BNZ, 1, 99);    // R7 not taken
    runInstr(OP_STORE, 1, 99);
    runInstr(OP_HALT, 0, 99);   // R8
    haltedCycles(8);
    doReset();                  // R1 leaves the terminal state
    runInstr(OP_MOVI, 1, 99);
    runInstr(4'b1001, 0, 99);   // R8 undefined opcode
    haltedCycles(4);
    doReset();
    runInstr(OP_LOAD, 0, 4);    // stop inside memory access
    doReset();                  // R1 mid-instruction
    runInstr(OP_ADD, 1, 99);
    runInstr(4'b1110, 1, 99);   // R8 undefined opcode
    haltedCycles(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL R1: watchdog actual=%0d cycles expected fewer", WATCHDOG_CYCLES);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule